// File: doc/BRIEF.md
# Idle Mode Power Controller

This block decides when the processor core's clock runs. When the core issues a power-save request with the idle mode selected, the controller withholds the CPU clock enable. The system clock that feeds the peripherals is never touched. The controller sends the watchdog counter a single-cycle clear as the mode is entered. It then waits for a wake event: an interrupt request whose own enable bit is set, a watchdog time-out, or a reset.

On wake, the CPU clock enable returns in the very next cycle. A one-cycle wake pulse goes out with it, together with a resume-target flag. The flag tells the core whether to continue at the instruction after the power-save request or to take the interrupt vector. An enabled interrupt that shows up in the same cycle as the request does not stop the entry. It is latched, entry finishes, and the block then wakes at once. While the core sleeps, a keep-alive request for the low-power oscillator is raised whenever the watchdog or the clock monitor is switched on.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: During and right after reset, `cpu_clk_en`=1, `wake`=0, `wdt_clr`=0, `resume_isr`=0 and `lpo_keep`=0.
- R2: A `psave_req`=1 with `psave_mode`=1 (1 selects idle) in a cycle where `cpu_clk_en`=1 drives `cpu_clk_en` to 0 from the next cycle. It stays 0 until a wake.
- R3: `wdt_clr` is high for exactly one cycle: the cycle right after an accepted idle request. It is low in every other cycle.
- R4: In idle, an interrupt with `irq_req[i]`=1 and `irq_en[i]`=1 makes `cpu_clk_en`=1 and `wake`=1 in the next cycle, with `resume_isr`=1. `wake` lasts one cycle.
- R5: In idle, `wdt_timeout`=1 with no enabled interrupt wakes the same way, with `resume_isr`=0.
- R6: An enabled interrupt present in the request cycle is held. Entry still completes: `cpu_clk_en` is low for exactly two cycles. The third cycle after the request shows `cpu_clk_en`=1, `wake`=1 and `resume_isr`=1.
- R7: A request with `irq_en[i]`=0 has no effect: `cpu_clk_en` stays 0 in idle.
- R8: A request with `psave_mode`=0 is ignored. A request while `cpu_clk_en`=0 is also ignored: it gives no `wdt_clr` and no change in `cpu_clk_en`.
- R9: `lpo_keep` equals (`wdt_on` OR `fscm_on`) while `cpu_clk_en`=0. It is 0 while `cpu_clk_en`=1.
- R10: Reset during idle returns at once to `cpu_clk_en`=1 with `resume_isr`=0.
- R11: If an enabled interrupt and a watchdog time-out wake together, `resume_isr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| psave_req | input | 1 | power-save request strobe from the core |
| psave_mode | input | 1 | 1 selects idle, 0 another mode (ignored here) |
| irq_req | input | N_IRQ | per-source interrupt requests |
| irq_en | input | N_IRQ | per-source interrupt enables |
| wdt_timeout | input | 1 | watchdog time-out |
| wdt_on | input | 1 | watchdog is enabled |
| fscm_on | input | 1 | clock-fail monitor is enabled |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_clr | output | 1 | one-cycle watchdog clear |
| wake | output | 1 | one-cycle wake pulse, first running cycle |
| resume_isr | output | 1 | 1: resume at interrupt vector, 0: next instruction |
| lpo_keep | output | 1 | keep low-power oscillator running |

## Verification
A stuck or wrong state register shows at `cpu_clk_en` within one cycle. Examples: an entry state that lasts too long, an idle that never leaves, or a wake from a disabled source. `wdt_clr` exposes a missing or repeated entry state in the cycle after the request. A lost latched coincident interrupt leaves the core asleep past the third cycle. A wrong wake cause appears on `resume_isr` in the cycle the clock returns. The bench checks every cycle of each idle episode, over random gaps and triggers.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_IDLE  = 2'd2
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       pending;
        logic       wake;
        logic       resume;
    } pwr_regs_t;

    localparam pwr_regs_t PWR_RESET = '{
        state:   ST_RUN,
        pending: 1'b0,
        wake:    1'b0,
        resume:  1'b0
    };

endpackage

// File: rtl/idle_irq_qual.sv
module idle_irq_qual #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             any_hit
);
    logic [N_IRQ-1:0] hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign hit[i] = irq_req[i] & irq_en[i];
    end

    assign any_hit = |hit;
endmodule

// File: rtl/idle_wake_sel.sv
module idle_wake_sel (
    input  logic in_idle,
    input  logic pending_q,
    input  logic irq_hit,
    input  logic wdt_timeout,
    output logic wake_go,
    output logic wake_by_irq
);
    always_comb begin
        wake_by_irq = pending_q | irq_hit;
        wake_go     = in_idle & (wake_by_irq | wdt_timeout);
    end
endmodule

// File: rtl/idle_pwr_fsm.sv
module idle_pwr_fsm
    import idle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psave_req,
    input  logic       psave_mode,
    input  logic       irq_hit,
    input  logic       wake_go,
    input  logic       wake_by_irq,
    output pwr_state_e state,
    output logic       pending,
    output logic       wake,
    output logic       resume
);
    pwr_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.wake = 1'b0;
        unique case (r_q.state)
            ST_RUN: begin
                if (psave_req && psave_mode) begin
                    r_d.state   = ST_ENTER;
                    r_d.pending = irq_hit;
                end
            end
            ST_ENTER: begin
                r_d.state   = ST_IDLE;
                r_d.pending = r_q.pending | irq_hit;
            end
            ST_IDLE: begin
                if (wake_go) begin
                    r_d.state   = ST_RUN;
                    r_d.wake    = 1'b1;
                    r_d.resume  = wake_by_irq;
                    r_d.pending = 1'b0;
                end
            end
            default: r_d = PWR_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= PWR_RESET;
        else        r_q <= r_d;
    end

    assign state   = r_q.state;
    assign pending = r_q.pending;
    assign wake    = r_q.wake;
    assign resume  = r_q.resume;
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
    import idle_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psave_req,
    input  logic             psave_mode,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    input  logic             wdt_on,
    input  logic             fscm_on,
    output logic             cpu_clk_en,
    output logic             wdt_clr,
    output logic             wake,
    output logic             resume_isr,
    output logic             lpo_keep
);
    pwr_state_e state;
    logic       irq_hit, pending_q, wake_go, wake_by_irq;

    idle_irq_qual #(.N_IRQ(N_IRQ)) u_qual (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .any_hit (irq_hit)
    );

    idle_wake_sel u_sel (
        .in_idle     (state == ST_IDLE),
        .pending_q   (pending_q),
        .irq_hit     (irq_hit),
        .wdt_timeout (wdt_timeout),
        .wake_go     (wake_go),
        .wake_by_irq (wake_by_irq)
    );

    idle_pwr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .psave_req   (psave_req),
        .psave_mode  (psave_mode),
        .irq_hit     (irq_hit),
        .wake_go     (wake_go),
        .wake_by_irq (wake_by_irq),
        .state       (state),
        .pending     (pending_q),
        .wake        (wake),
        .resume      (resume_isr)
    );

    always_comb begin
        cpu_clk_en = (state == ST_RUN);
        wdt_clr    = (state == ST_ENTER);
        lpo_keep   = (state != ST_RUN) && (wdt_on || fscm_on);
    end
endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk #(
    parameter int N_IRQ = 8
) (
    input logic clk,
    input logic rst_n,
    input logic psave_req,
    input logic psave_mode,
    input logic wdt_on,
    input logic fscm_on,
    input logic cpu_clk_en,
    input logic wdt_clr,
    input logic wake,
    input logic lpo_keep
);
    // R3: clear is a single pulse
    a_r3_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);

    // R2, R3: accepted request gates clock and clears watchdog
    a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && psave_req && psave_mode) |=> (!cpu_clk_en && wdt_clr));

    // R8: non-idle mode request ignored
    a_r8_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && psave_req && !psave_mode) |=> cpu_clk_en);

    // R4: clock returns only with a wake pulse
    a_r4_wake_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> wake);

    // R4: wake pulse lasts one cycle
    a_r4_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R9: oscillator keep-alive only while gated
    a_r9_lpo: assert property (@(posedge clk) disable iff (!rst_n)
        lpo_keep |-> (!cpu_clk_en && (wdt_on || fscm_on)));
endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .psave_req  (psave_req),
    .psave_mode (psave_mode),
    .wdt_on     (wdt_on),
    .fscm_on    (fscm_on),
    .cpu_clk_en (cpu_clk_en),
    .wdt_clr    (wdt_clr),
    .wake       (wake),
    .lpo_keep   (lpo_keep)
);

// File: tb/idle_pwr_ctrl_test.sv
`timescale 1ns/1ps
module idle_pwr_ctrl_test;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psave_req = 1'b0, psave_mode = 1'b0;
    logic [N-1:0] irq_req = '0, irq_en = '0;
    logic wdt_timeout = 1'b0, wdt_on = 1'b0, fscm_on = 1'b0;
    logic cpu_clk_en, wdt_clr, wake, resume_isr, lpo_keep;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    idle_pwr_ctrl #(.N_IRQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .psave_req(psave_req), .psave_mode(psave_mode),
        .irq_req(irq_req), .irq_en(irq_en), .wdt_timeout(wdt_timeout),
        .wdt_on(wdt_on), .fscm_on(fscm_on), .cpu_clk_en(cpu_clk_en),
        .wdt_clr(wdt_clr), .wake(wake), .resume_isr(resume_isr), .lpo_keep(lpo_keep)
    );

    function automatic logic exp_lpo(input logic gated, input logic w, input logic f);
        return gated && (w || f);
    endfunction

    function automatic logic exp_resume(input int trig);
        return (trig != 1);  // 0 irq, 1 wdt only, 2 both
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic noise();
        logic [N-1:0] e;
        e = N'($urandom);
        irq_en = e;
        irq_req = N'($urandom) & ~e;
        wdt_timeout = 1'b0;
    endtask

    task automatic episode(input bit coinc, input int gap, input int trig);
        int b;
        b = int'($urandom_range(N-1, 0));
        psave_req = 1'b1;
        psave_mode = 1'b1;
        if (coinc) begin
            irq_req = '0; irq_en = '0;
            irq_req[b] = 1'b1; irq_en[b] = 1'b1;
        end else noise();
        step();
        chk("R2 gated after request", cpu_clk_en, 1'b0);
        chk("R3 clear in entry cycle", wdt_clr, 1'b1);
        chk("R9 lpo in entry", lpo_keep, exp_lpo(1'b1, wdt_on, fscm_on));
        psave_req = 1'b0;
        noise();
        step();
        chk("R2 gated in idle", cpu_clk_en, 1'b0);
        chk("R3 clear only once", wdt_clr, 1'b0);
        if (coinc) begin
            noise();
            step();
            chk("R6 coincident wake clk", cpu_clk_en, 1'b1);
            chk("R6 coincident wake pulse", wake, 1'b1);
            chk("R6 coincident resume", resume_isr, 1'b1);
        end else begin
            for (int k = 0; k < gap; k++) begin
                noise();
                step();
                chk("R7 disabled irq no wake", cpu_clk_en, 1'b0);
                chk("R9 lpo in idle", lpo_keep, exp_lpo(1'b1, wdt_on, fscm_on));
            end
            noise();
            if (trig != 1) begin irq_req[b] = 1'b1; irq_en[b] = 1'b1; end
            if (trig != 0) wdt_timeout = 1'b1;
            step();
            chk("R4/R5 wake clk", cpu_clk_en, 1'b1);
            chk("R4/R5 wake pulse", wake, 1'b1);
            if (trig == 0) chk("R4 irq resume", resume_isr, exp_resume(trig));
            else if (trig == 1) chk("R5 wdt resume", resume_isr, exp_resume(trig));
            else chk("R11 both resume", resume_isr, exp_resume(trig));
        end
        irq_req = '0; irq_en = '0; wdt_timeout = 1'b0;
        step();
        chk("R4 wake one cycle", wake, 1'b0);
        chk("R9 lpo off when running", lpo_keep, 1'b0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hung expected finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        wdt_on = 1'b1;
        #2;
        chk("R1 reset clk_en", cpu_clk_en, 1'b1);
        chk("R1 reset wake", wake, 1'b0);
        chk("R1 reset wdt_clr", wdt_clr, 1'b0);
        chk("R1 reset lpo", lpo_keep, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        chk("R1 after reset clk_en", cpu_clk_en, 1'b1);
        chk("R1 after reset resume", resume_isr, 1'b0);

        // R8: request with the other mode is ignored
        psave_req = 1'b1; psave_mode = 1'b0;
        step();
        chk("R8 other mode ignored clk", cpu_clk_en, 1'b1);
        chk("R8 other mode no clear", wdt_clr, 1'b0);
        psave_req = 1'b0;

        // directed episodes
        episode(1'b0, 0, 0);
        episode(1'b0, 3, 1);
        episode(1'b1, 0, 0);
        episode(1'b0, 2, 2);

        // R8: request while idle ignored; R10: reset during idle
        psave_req = 1'b1; psave_mode = 1'b1;
        step();
        step();
        chk("R8 in idle state", cpu_clk_en, 1'b0);
        step();
        chk("R8 request in idle no clear", wdt_clr, 1'b0);
        chk("R8 request in idle stays gated", cpu_clk_en, 1'b0);
        psave_req = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R10 reset wakes", cpu_clk_en, 1'b1);
        chk("R10 reset resume", resume_isr, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        chk("R10 running after reset", cpu_clk_en, 1'b1);

        // random episodes
        for (int it = 0; it < 60; it++) begin
            wdt_on  = 1'($urandom);
            fscm_on = 1'($urandom);
            episode(($urandom % 4) == 0, int'($urandom % 6), int'($urandom % 3));
        end

        summary();
        $finish;
    end
endmodule